// File: doc/BRIEF.md
# Standby Control Register Unit

This unit holds an 8-bit power-mode control register on a simple memory-mapped bus and turns a sleep-instruction pulse into a low-power request. Two live bits in the register decide what the pulse does: a standby-select bit picks standby over plain sleep, and a port-float bit decides whether the device's I/O pins float while standby is held. The remaining six bits are fixed at read-back and ignore writes.

Both live bits are guarded by the watchdog: while the watchdog-enable input is high, a write cannot raise either bit, though it may always clear them. On a sleep pulse in run mode the unit samples the standby-select bit, raises either the sleep or the standby request, and holds it until a wake pulse brings it back to run mode. The port high-impedance enable is raised only while in standby with the port-float bit set.

Top module: `stby_ctl_unit`

## Requirements
- R1: After synchronous reset the register reads 0x1F, and sleep_req, standby_req and port_hiz are all 0.
- R2: A write with wr_en=1 and wr_be[0]=1 while wdt_en=0 loads wr_data[7] into the standby-select bit and wr_data[6] into the port-float bit; with wr_be[0]=0 the register is unchanged whatever the other lanes carry.
- R3: While wdt_en=1 a write cannot change the standby-select bit (bit 7) from 0 to 1; it keeps its previous value.
- R4: While wdt_en=1 a write cannot change the port-float bit (bit 6) from 0 to 1; it keeps its previous value.
- R5: A write of 0 to bit 7 or bit 6 clears that bit whatever the value of wdt_en.
- R6: rd_data bit 5 always reads 0, bits 4..0 always read 1, and bits 31..8 always read 0, regardless of any write.
- R7: A sleep_pulse in run mode with bit 7 = 0 makes sleep_req 1 from the following cycle until a wake_pulse.
- R8: A sleep_pulse in run mode with bit 7 = 1 makes standby_req 1 from the following cycle until a wake_pulse.
- R9: port_hiz is 1 exactly when standby_req is 1 and bit 6 is 1; it is 0 in run and sleep modes.
- R10: A wake_pulse in sleep or standby returns to run mode on the next cycle; a sleep_pulse outside run mode and a wake_pulse in run mode have no effect; a sleep_pulse in run mode wins over a simultaneous wake_pulse.
- R11: When a sleep_pulse and a register write fall in the same cycle, the mode is chosen from the register value held before that write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte-lane enables; only lane 0 maps onto the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register value, zero-extended |
| wdt_en | input | 1 | Watchdog running; blocks setting bits 7 and 6 |
| sleep_pulse | input | 1 | One-cycle pulse from a sleep instruction |
| wake_pulse | input | 1 | One-cycle pulse returning to run mode |
| sleep_req | output | 1 | Sleep mode requested |
| standby_req | output | 1 | Standby mode requested |
| port_hiz | output | 1 | Float the I/O ports |

## Verification
A bus write and a sleep pulse can arrive in the same cycle, and so can a sleep pulse and a wake pulse. The bench drives the write together with the sleep pulse in both directions (raising and clearing the standby-select bit) and judges that the chosen request follows the value held before the write while a read one cycle later shows the written value. It also pulses sleep and wake together in run mode and expects the sleep pulse to win.

// File: rtl/stby_pkg.sv
package stby_pkg;

    localparam int REG_W    = 8;
    localparam int SBY_BIT  = 7;
    localparam int HIZ_BIT  = 6;
    localparam int ZERO_BIT = 5;
    localparam int ONES_W   = 5;
    localparam logic [REG_W-1:0] RST_VAL = 8'h1F;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_SLEEP = 2'd1,
        MODE_STBY  = 2'd2
    } pwr_mode_e;

    typedef struct packed {
        logic sby;
        logic hiz;
    } mode_bits_t;

    // Watchdog gating: while it runs, a bit may only fall or stay.
    function automatic logic gate_bit(input logic cur, input logic req, input logic wdt);
        return wdt ? (cur & req) : req;
    endfunction

    // Register image with the fixed reserved pattern.
    function automatic logic [REG_W-1:0] fmt_byte(input mode_bits_t b);
        logic [REG_W-1:0] v;
        v = '0;
        v[SBY_BIT]      = b.sby;
        v[HIZ_BIT]      = b.hiz;
        v[ZERO_BIT]     = 1'b0;
        v[ONES_W-1:0]   = '1;
        return v;
    endfunction

endpackage

// File: rtl/stby_ctl_regs.sv
module stby_ctl_regs
    import stby_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_lane,
    input  logic [REG_W-1:0] wr_byte,
    input  logic             wdt_en,
    output mode_bits_t       bits_q
);

    mode_bits_t bits_d;

    always_comb begin
        bits_d = bits_q;
        if (wr_en && wr_lane) begin
            bits_d.sby = gate_bit(bits_q.sby, wr_byte[SBY_BIT], wdt_en);
            bits_d.hiz = gate_bit(bits_q.hiz, wr_byte[HIZ_BIT], wdt_en);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '{sby: RST_VAL[SBY_BIT], hiz: RST_VAL[HIZ_BIT]};
        end else begin
            bits_q <= bits_d;
        end
    end

    // R3: watchdog blocks raising the standby-select bit
    p_sby_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_lane && wdt_en && !bits_q.sby) |=> !bits_q.sby)
        else $error("p_sby_hold_r3");

    // R4: watchdog blocks raising the port-float bit
    p_hiz_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_lane && wdt_en && !bits_q.hiz) |=> !bits_q.hiz)
        else $error("p_hiz_hold_r4");

    // R5: clearing is always honoured
    p_sby_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_lane && !wr_byte[SBY_BIT]) |=> !bits_q.sby)
        else $error("p_sby_clear_r5");

    p_hiz_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_lane && !wr_byte[HIZ_BIT]) |=> !bits_q.hiz)
        else $error("p_hiz_clear_r5");

    // R2: no lane-0 write, no change
    p_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_lane) |=> $stable(bits_q))
        else $error("p_no_write_r2");

endmodule

// File: rtl/stby_read_fmt.sv
module stby_read_fmt
    import stby_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  mode_bits_t       bits,
    output logic [BUS_W-1:0] rd_data
);

    localparam int PAD_W = BUS_W - REG_W;

    logic [REG_W-1:0] img;
    assign img = fmt_byte(bits);

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = {{PAD_W{1'b0}}, img};
        end else begin : g_nopad
            assign rd_data = img[BUS_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/stby_mode_ctl.sv
module stby_mode_ctl
    import stby_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_pulse,
    input  logic       wake_pulse,
    input  mode_bits_t bits,
    output logic       sleep_req,
    output logic       standby_req,
    output logic       port_hiz
);

    pwr_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            MODE_RUN: begin
                if (sleep_pulse) begin
                    state_d = bits.sby ? MODE_STBY : MODE_SLEEP;
                end
            end
            default: begin
                if (wake_pulse) begin
                    state_d = MODE_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MODE_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    assign sleep_req   = (state_q == MODE_SLEEP);
    assign standby_req = (state_q == MODE_STBY);
    assign port_hiz    = standby_req && bits.hiz;

    // R7: sleep entry
    p_sleep_entry_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == MODE_RUN && sleep_pulse && !bits.sby) |=> sleep_req)
        else $error("p_sleep_entry_r7");

    // R8: standby entry
    p_stby_entry_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == MODE_RUN && sleep_pulse && bits.sby) |=> standby_req)
        else $error("p_stby_entry_r8");

    // R10: wake returns to run
    p_wake_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q != MODE_RUN && wake_pulse) |=> (!sleep_req && !standby_req))
        else $error("p_wake_r10");

    // R10: requests hold without wake
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q != MODE_RUN && !wake_pulse) |=> $stable(state_q))
        else $error("p_hold_r10");

    p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sleep_req, standby_req}))
        else $error("p_onehot_r10");

endmodule

// File: rtl/stby_ctl_unit.sv
module stby_ctl_unit
    import stby_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [BUS_W/8-1:0] wr_be,
    input  logic [BUS_W-1:0] wr_data,
    output logic [BUS_W-1:0] rd_data,
    input  logic             wdt_en,
    input  logic             sleep_pulse,
    input  logic             wake_pulse,
    output logic             sleep_req,
    output logic             standby_req,
    output logic             port_hiz
);

    localparam int BE_W = BUS_W / 8;

    mode_bits_t bits;
    logic       unused_lanes;

    assign unused_lanes = ^{wr_data[BUS_W-1:REG_W], wr_be[BE_W-1:1]};

    stby_ctl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_lane (wr_be[0]),
        .wr_byte (wr_data[REG_W-1:0]),
        .wdt_en  (wdt_en),
        .bits_q  (bits)
    );

    stby_read_fmt #(.BUS_W(BUS_W)) u_fmt (
        .bits    (bits),
        .rd_data (rd_data)
    );

    stby_mode_ctl u_mode (
        .clk         (clk),
        .rst         (rst),
        .sleep_pulse (sleep_pulse),
        .wake_pulse  (wake_pulse),
        .bits        (bits),
        .sleep_req   (sleep_req),
        .standby_req (standby_req),
        .port_hiz    (port_hiz)
    );

    // R6: fixed reserved pattern on the read port
    p_fixed_bits_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_data[ZERO_BIT:0] == 6'h1F) && (rd_data[BUS_W-1:REG_W] == '0))
        else $error("p_fixed_bits_r6");

    // R9: ports float only in standby
    p_hiz_only_stby_r9: assert property (@(posedge clk) disable iff (rst)
        port_hiz |-> (standby_req && rd_data[HIZ_BIT]))
        else $error("p_hiz_only_stby_r9");

endmodule

// File: tb/stby_ctl_unit_tb_top.sv
module stby_ctl_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        wdt_en = 1'b0;
    logic        sleep_pulse = 1'b0;
    logic        wake_pulse = 1'b0;
    logic        sleep_req, standby_req, port_hiz;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stby_ctl_unit dut_i (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_be       (wr_be),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .wdt_en      (wdt_en),
        .sleep_pulse (sleep_pulse),
        .wake_pulse  (wake_pulse),
        .sleep_req   (sleep_req),
        .standby_req (standby_req),
        .port_hiz    (port_hiz)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog expired act=%0d exp<=%0d", cycles, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] img(input logic s, input logic h);
        return {24'h0, s, h, 1'b0, 5'h1F};
    endfunction

    function automatic logic [31:0] outs();
        return {29'h0, sleep_req, standby_req, port_hiz};
    endfunction

    // All tasks start and end at a falling edge.
    task automatic bus_write(input logic [31:0] d, input logic [3:0] be, input logic wdt);
        wr_en = 1'b1; wr_be = be; wr_data = d; wdt_en = wdt;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0; wr_data = '0; wdt_en = 1'b0;
    endtask

    task automatic pulse(input logic slp, input logic wk);
        sleep_pulse = slp; wake_pulse = wk;
        @(negedge clk);
        sleep_pulse = 1'b0; wake_pulse = 1'b0;
    endtask

    initial begin
        logic es, eh;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 reset read", rd_data, 32'h0000_001F);
        chk("R1 reset outputs", outs(), 32'h0);

        // R2 R3 R4 R5 R6: sweep start bits x watchdog x every data byte
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 2; w++) begin
                for (int d = 0; d < 256; d++) begin
                    bus_write({24'h0, s[1:0], 6'h0}, 4'h1, 1'b0);
                    bus_write({d[7:0], d[7:0], d[7:0], d[7:0]}, 4'hF, w[0]);
                    es = w[0] ? (s[1] & d[7]) : d[7];
                    eh = w[0] ? (s[0] & d[6]) : d[6];
                    chk("R2 R3 R4 R5 R6 sweep", rd_data, img(es, eh));
                end
            end
        end

        // R2: byte-lane sweep, only lane 0 writes
        for (int be = 0; be < 16; be++) begin
            bus_write(32'h0, 4'h1, 1'b0);
            bus_write(32'hFFFF_FFFF, be[3:0], 1'b0);
            chk("R2 lane enable", rd_data, img(be[0], be[0]));
        end

        // R7 R8 R9 R10: every combination of select bits
        for (int s = 0; s < 4; s++) begin
            bus_write({24'h0, s[1:0], 6'h0}, 4'h1, 1'b0);
            chk("R10 run before sleep", outs(), 32'h0);
            pulse(1'b0, 1'b1);
            chk("R10 wake in run ignored", outs(), 32'h0);
            pulse(1'b1, 1'b0);
            chk(s[1] ? "R8 standby entry" : "R7 sleep entry",
                outs(), {29'h0, ~s[1], s[1], s[1] & s[0]});
            chk("R9 port float", {31'h0, port_hiz}, {31'h0, s[1] & s[0]});
            repeat (3) @(negedge clk);
            pulse(1'b1, 1'b0);
            chk("R10 held, sleep outside run ignored", outs(),
                {29'h0, ~s[1], s[1], s[1] & s[0]});
            pulse(1'b0, 1'b1);
            chk("R10 wake to run", outs(), 32'h0);
        end

        // R9: float bit changed during standby follows live bit
        bus_write(32'h80, 4'h1, 1'b0);
        pulse(1'b1, 1'b0);
        chk("R9 standby without float", outs(), 32'h2);
        bus_write(32'hC0, 4'h1, 1'b0);
        chk("R9 standby with float", outs(), 32'h3);
        pulse(1'b0, 1'b1);
        chk("R9 run clears float", outs(), 32'h0);

        // R10: sleep and wake together in run, sleep wins
        bus_write(32'h00, 4'h1, 1'b0);
        pulse(1'b1, 1'b1);
        chk("R10 sleep beats wake", outs(), 32'h4);
        pulse(1'b0, 1'b1);

        // R11: write raising select with sleep pulse -> old value (sleep)
        wr_en = 1'b1; wr_be = 4'h1; wr_data = 32'hC0; sleep_pulse = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0; wr_data = '0; sleep_pulse = 1'b0;
        chk("R11 mode from old value", outs(), 32'h4);
        chk("R11 write applied", rd_data, img(1'b1, 1'b1));
        pulse(1'b0, 1'b1);

        // R11: write clearing select with sleep pulse -> old value (standby)
        wr_en = 1'b1; wr_be = 4'h1; wr_data = 32'h00; sleep_pulse = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0; wr_data = '0; sleep_pulse = 1'b0;
        chk("R11 standby from old value", outs(), 32'h2);
        chk("R11 clear applied", rd_data, img(1'b0, 1'b0));
        pulse(1'b0, 1'b1);

        // R1: reset from standby
        bus_write(32'hC0, 4'h1, 1'b0);
        pulse(1'b1, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset from standby read", rd_data, 32'h0000_001F);
        chk("R1 reset from standby outputs", outs(), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule